// File: doc/BRIEF.md
# Exception Pending-State Control Register

This block is a single 32-bit memory-mapped control and status word for an interrupt controller. Software uses it to make three system exceptions pending or not pending: the non-maskable interrupt, a deferred-service exception and a system-timer exception. Each of the two maskable system exceptions has a write-one-to-set bit and a write-one-to-clear bit. The NMI has only a set bit, and that bit is cleared when the handler is entered. Written zeros never change any state.

The same word also reports status read back from hardware. It shows whether any external interrupt line is pending and which exception has the highest priority among those that are pending. The external lines are gated by their enable and mask vectors, and no global priority-mask qualifier is applied. The word also shows which exception number was entered most recently.

When the core enters an exception, it acknowledges the entry with the exception's number. The block then clears the pending bit of that exception and loads the number into the active field. A timer tick pulse from hardware makes the timer exception pending, and an NMI request pulse makes the NMI pending. A preempt flag from outside, which is meaningful only while the core is halted, is copied into the word without change.

Top module: `excp_ctrl_reg`

## Requirements
- R1: A write with bit 31 set makes the NMI pending, and so does a pulse on `nmi_req`. A write with bit 31 clear leaves the NMI state unchanged. Read bit 31 shows whether the NMI is pending.
- R2: An acknowledge of exception number 2 clears the NMI pending bit. If `nmi_req` is high in the same cycle as that acknowledge, the NMI stays pending.
- R3: A write with bit 28 set makes the deferred-service exception pending. A write with bit 27 set clears it. If both bits are set in one write, the clear wins. Zero bits have no effect. Read bit 28 shows the deferred-service pending state.
- R4: The deferred-service exception becomes pending only through a software write of bit 28. The timer tick, `nmi_req` and the external lines never set it.
- R5: A write with bit 26 set makes the timer exception pending, and so does a pulse on `tick_pulse`. A write with bit 25 set clears it, and the clear wins over a set in the same write. Read bit 26 shows the timer pending state. Read bit 25 is always 0.
- R6: Read bits [20:12] give the exception number of the highest-priority pending exception, or 0 when none is pending. The NMI (number 2) always wins. Among the others, the lower priority value wins, and on a tie the lower exception number wins. The deferred-service exception is number 14, the timer is number 15, and external line i is number 16+i.
- R7: External line i takes part in the R6 selection only when `irq_pend[i]` is 1, `irq_en[i]` is 1 and `irq_mask[i]` is 0.
- R8: Read bit 22 is 1 when any bit of `irq_pend` is 1, whatever the enable and mask vectors hold.
- R9: An acknowledge loads `ack_num` into read bits [8:0], and it clears the pending bit of exception 14 or 15 when that number is acknowledged. Reset sets the active field and all pending bits to 0. Read bit 23 follows the `halt_preempt` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register read value |
| nmi_req | input | 1 | NMI request pulse |
| tick_pulse | input | 1 | System-timer tick pulse |
| irq_pend | input | NUM_IRQ | External interrupt pending lines |
| irq_en | input | NUM_IRQ | External interrupt enables |
| irq_mask | input | NUM_IRQ | External interrupt masks (1 = masked) |
| defer_prio | input | PRIO_W | Deferred-service exception priority |
| tick_prio | input | PRIO_W | Timer exception priority |
| irq_prio | input | NUM_IRQ*PRIO_W | Flattened external priorities, line i at [i*PRIO_W +: PRIO_W] |
| ack_valid | input | 1 | Exception-entry acknowledge |
| ack_num | input | 9 | Number of the exception being entered |
| halt_preempt | input | 1 | Halted-core preempt flag |

## Verification
The hardest case to reach is an NMI request that arrives in the same cycle as the acknowledge of the NMI. This models the NMI being asserted again while its own handler is being entered. The bench drives `nmi_req` and `ack_valid` with number 2 in the same cycle, checks that bit 31 still reads 1, and then sends a second acknowledge to show that the bit clears. Priority ties come next in difficulty: the bench programs equal priority values for the timer and the deferred-service exception, and then gives an enabled external line a lower value, so that it must overtake both.

// File: rtl/excp_pkg.sv
// Shared constants for the exception pending-state register.
// Assumes a 32-bit register word and 9-bit exception numbers.
package excp_pkg;
    localparam int VEC_W = 9;

    // Fixed exception numbers
    localparam logic [VEC_W-1:0] NUM_NMI   = 9'd2;
    localparam logic [VEC_W-1:0] NUM_DEFER = 9'd14;
    localparam logic [VEC_W-1:0] NUM_TICK  = 9'd15;
    localparam int               IRQ_BASE  = 16;

    // Bit positions within the register word
    localparam int B_ACT_LO  = 0;
    localparam int B_PEND_LO = 12;
    localparam int B_EXTP    = 22;
    localparam int B_PREEMPT = 23;
    localparam int B_TCLR    = 25;
    localparam int B_TSET    = 26;
    localparam int B_DCLR    = 27;
    localparam int B_DSET    = 28;
    localparam int B_NSET    = 31;
endpackage

// File: rtl/excp_pend_bits.sv
// Pending-state flops for NMI, deferred-service and timer exceptions.
// Assumes write strobes already decoded to single bits; the clear of a
// maskable exception beats its set; an NMI request beats the NMI acknowledge.
module excp_pend_bits
    import excp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             w_nset,
    input  logic             w_dset,
    input  logic             w_dclr,
    input  logic             w_tset,
    input  logic             w_tclr,
    input  logic             nmi_req,
    input  logic             tick_pulse,
    input  logic             ack_valid,
    input  logic [VEC_W-1:0] ack_num,
    output logic             nmi_pend,
    output logic             defer_pend,
    output logic             tick_pend
);
    logic ack_nmi, ack_defer, ack_tick;

    // Decode which exception an entry acknowledge refers to
    always_comb begin
        ack_nmi   = ack_valid && (ack_num == NUM_NMI);
        ack_defer = ack_valid && (ack_num == NUM_DEFER);
        ack_tick  = ack_valid && (ack_num == NUM_TICK);
    end

    // Update the three pending bits from writes, hardware pulses and entries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_pend   <= 1'b0;
            defer_pend <= 1'b0;
            tick_pend  <= 1'b0;
        end else begin
            nmi_pend   <= w_nset || nmi_req || (nmi_pend && !ack_nmi);
            defer_pend <= (defer_pend || w_dset) && !(w_dclr || ack_defer);
            tick_pend  <= (tick_pend || w_tset || tick_pulse) && !(w_tclr || ack_tick);
        end
    end
endmodule

// File: rtl/excp_prio_pick.sv
// Combinational selection of the highest-priority pending exception.
// Assumes a lower priority value is more urgent; candidates are scanned in
// ascending exception number with a strict compare, so ties go to the lower
// number. The NMI overrides every other candidate.
module excp_prio_pick
    import excp_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3
) (
    input  logic                      nmi_pend,
    input  logic                      defer_pend,
    input  logic                      tick_pend,
    input  logic [PRIO_W-1:0]         defer_prio,
    input  logic [PRIO_W-1:0]         tick_prio,
    input  logic [NUM_IRQ-1:0]        irq_pend,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [NUM_IRQ-1:0]        irq_mask,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    output logic [VEC_W-1:0]          pend_vec
);
    localparam int NCAND = NUM_IRQ + 2;

    logic [NCAND-1:0] cand_ok;
    logic [PRIO_W-1:0] cand_pri [NCAND];
    logic [VEC_W-1:0]  cand_num [NCAND];

    // Slots 0 and 1 hold the two system exceptions
    always_comb begin
        cand_ok[0]  = defer_pend;
        cand_pri[0] = defer_prio;
        cand_num[0] = NUM_DEFER;
        cand_ok[1]  = tick_pend;
        cand_pri[1] = tick_prio;
        cand_num[1] = NUM_TICK;
    end

    // One slot per external line, gated by its enable and mask
    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_irq
        always_comb begin
            cand_ok[gi+2]  = irq_pend[gi] && irq_en[gi] && !irq_mask[gi];
            cand_pri[gi+2] = irq_prio[gi*PRIO_W +: PRIO_W];
            cand_num[gi+2] = VEC_W'(IRQ_BASE + gi);
        end
    end

    logic              best_ok;
    logic [PRIO_W-1:0] best_pri;
    logic [VEC_W-1:0]  best_num;

    // Scan the candidates and keep the most urgent one
    always_comb begin
        best_ok  = 1'b0;
        best_pri = '0;
        best_num = '0;
        for (int k = 0; k < NCAND; k++) begin
            if (cand_ok[k] && (!best_ok || (cand_pri[k] < best_pri))) begin
                best_ok  = 1'b1;
                best_pri = cand_pri[k];
                best_num = cand_num[k];
            end
        end
        if (nmi_pend)
            pend_vec = NUM_NMI;
        else if (best_ok)
            pend_vec = best_num;
        else
            pend_vec = '0;
    end
endmodule

// File: rtl/excp_active_reg.sv
// Holds the number of the most recently entered exception.
// Assumes the core presents one acknowledge per entry; reset gives 0.
module excp_active_reg
    import excp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_valid,
    input  logic [VEC_W-1:0] ack_num,
    output logic [VEC_W-1:0] active_num
);
    // Capture the acknowledged number on each entry
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_num <= '0;
        else if (ack_valid)
            active_num <= ack_num;
    end
endmodule

// File: rtl/excp_ctrl_reg.sv
// Top of the exception pending-state register: decodes writes, holds the
// pending bits and the active number, and assembles the read word.
// Assumes single-cycle write strobes and a combinational read path.
module excp_ctrl_reg
    import excp_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [31:0]               wr_data,
    output logic [31:0]               rd_data,
    input  logic                      nmi_req,
    input  logic                      tick_pulse,
    input  logic [NUM_IRQ-1:0]        irq_pend,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [NUM_IRQ-1:0]        irq_mask,
    input  logic [PRIO_W-1:0]         defer_prio,
    input  logic [PRIO_W-1:0]         tick_prio,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic                      ack_valid,
    input  logic [VEC_W-1:0]          ack_num,
    input  logic                      halt_preempt
);
    logic w_nset, w_dset, w_dclr, w_tset, w_tclr;
    logic nmi_pend, defer_pend, tick_pend;
    logic [VEC_W-1:0] pend_vec, active_num;

    // Decode the write-one strobes; zeros produce no strobe
    always_comb begin
        w_nset = wr_en && wr_data[B_NSET];
        w_dset = wr_en && wr_data[B_DSET];
        w_dclr = wr_en && wr_data[B_DCLR];
        w_tset = wr_en && wr_data[B_TSET];
        w_tclr = wr_en && wr_data[B_TCLR];
    end

    excp_pend_bits u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .w_nset     (w_nset),
        .w_dset     (w_dset),
        .w_dclr     (w_dclr),
        .w_tset     (w_tset),
        .w_tclr     (w_tclr),
        .nmi_req    (nmi_req),
        .tick_pulse (tick_pulse),
        .ack_valid  (ack_valid),
        .ack_num    (ack_num),
        .nmi_pend   (nmi_pend),
        .defer_pend (defer_pend),
        .tick_pend  (tick_pend)
    );

    excp_prio_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_pick (
        .nmi_pend   (nmi_pend),
        .defer_pend (defer_pend),
        .tick_pend  (tick_pend),
        .defer_prio (defer_prio),
        .tick_prio  (tick_prio),
        .irq_pend   (irq_pend),
        .irq_en     (irq_en),
        .irq_mask   (irq_mask),
        .irq_prio   (irq_prio),
        .pend_vec   (pend_vec)
    );

    excp_active_reg u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_valid  (ack_valid),
        .ack_num    (ack_num),
        .active_num (active_num)
    );

    // Assemble the read word; write-only and reserved bits read 0
    always_comb begin
        rd_data                               = '0;
        rd_data[B_ACT_LO  +: VEC_W]           = active_num;
        rd_data[B_PEND_LO +: VEC_W]           = pend_vec;
        rd_data[B_EXTP]                       = |irq_pend;
        rd_data[B_PREEMPT]                    = halt_preempt;
        rd_data[B_TSET]                       = tick_pend;
        rd_data[B_DSET]                       = defer_pend;
        rd_data[B_NSET]                       = nmi_pend;
    end
endmodule

// File: rtl/excp_ctrl_chk.sv
// Checker for excp_ctrl_reg, attached by bind. Observes ports only.
module excp_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        nmi_req,
    input logic        tick_pulse,
    input logic        ack_valid,
    input logic [8:0]  ack_num
);
    // R1: a written NMI set is visible on the next cycle
    a_r1_nmi_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31]) |=> rd_data[31]);

    // R2: an NMI acknowledge without a new request clears the pending bit
    a_r2_nmi_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_num == 9'd2 && !nmi_req && !(wr_en && wr_data[31])) |=> !rd_data[31]);

    // R3: a deferred-service clear always wins
    a_r3_defer_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[27]) |=> !rd_data[28]);

    // R4: the deferred-service bit only rises after a software set
    a_r4_defer_sw_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[28]) |-> $past(wr_en && wr_data[28]));

    // R5: a timer tick makes the timer pending unless cleared in the same cycle
    a_r5_tick_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_pulse && !(wr_en && wr_data[25]) && !(ack_valid && ack_num == 9'd15)) |=> rd_data[26]);

    // R5: the timer clear bit reads 0
    a_r5_tclr_reads0: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[25]);

    // R6: a pending NMI is always the reported vector
    a_r6_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31] |-> (rd_data[20:12] == 9'd2));

    // R9: an acknowledge loads the active field
    a_r9_active_load: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> (rd_data[8:0] == $past(ack_num)));
endmodule

bind excp_ctrl_reg excp_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .nmi_req    (nmi_req),
    .tick_pulse (tick_pulse),
    .ack_valid  (ack_valid),
    .ack_num    (ack_num)
);

// File: tb/sim_excp_ctrl_reg.sv
module sim_excp_ctrl_reg;
    localparam int CLK_P   = 10;
    localparam int NUM_IRQ = 8;
    localparam int PRIO_W  = 3;

    logic                      clk = 1'b0;
    logic                      rst_n;
    logic                      wr_en;
    logic [31:0]               wr_data;
    logic [31:0]               rd_data;
    logic                      nmi_req;
    logic                      tick_pulse;
    logic [NUM_IRQ-1:0]        irq_pend;
    logic [NUM_IRQ-1:0]        irq_en;
    logic [NUM_IRQ-1:0]        irq_mask;
    logic [PRIO_W-1:0]         defer_prio;
    logic [PRIO_W-1:0]         tick_prio;
    logic [NUM_IRQ*PRIO_W-1:0] irq_prio;
    logic                      ack_valid;
    logic [8:0]                ack_num;
    logic                      halt_preempt;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    excp_ctrl_reg #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .nmi_req(nmi_req), .tick_pulse(tick_pulse), .irq_pend(irq_pend), .irq_en(irq_en),
        .irq_mask(irq_mask), .defer_prio(defer_prio), .tick_prio(tick_prio),
        .irq_prio(irq_prio), .ack_valid(ack_valid), .ack_num(ack_num),
        .halt_preempt(halt_preempt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One-cycle write, result visible at the following negedge
    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ack(input logic [8:0] n);
        ack_valid = 1'b1; ack_num = n;
        @(negedge clk);
        ack_valid = 1'b0; ack_num = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset word", rd_data, 32'h0);
    endtask

    task automatic t_nmi;
        wr(32'h0);
        check("R1 zero write", {31'b0, rd_data[31]}, 32'd0);
        wr(32'h8000_0000);
        check("R1 set", {31'b0, rd_data[31]}, 32'd1);
        ack(9'd2);
        check("R2 ack clears", {31'b0, rd_data[31]}, 32'd0);
        check("R9 active 2", {23'b0, rd_data[8:0]}, 32'd2);
        nmi_req = 1'b1; @(negedge clk); nmi_req = 1'b0;
        check("R1 nmi_req sets", {31'b0, rd_data[31]}, 32'd1);
        nmi_req = 1'b1; ack_valid = 1'b1; ack_num = 9'd2;
        @(negedge clk);
        nmi_req = 1'b0; ack_valid = 1'b0; ack_num = '0;
        check("R2 reassert during entry", {31'b0, rd_data[31]}, 32'd1);
        ack(9'd2);
        check("R2 second ack", {31'b0, rd_data[31]}, 32'd0);
    endtask

    task automatic t_defer;
        wr(32'h1000_0000);
        check("R3 set", {31'b0, rd_data[28]}, 32'd1);
        wr(32'h0);
        check("R3 zero no effect", {31'b0, rd_data[28]}, 32'd1);
        wr(32'h0800_0000);
        check("R3 clear", {31'b0, rd_data[28]}, 32'd0);
        wr(32'h1800_0000);
        check("R3 clear wins", {31'b0, rd_data[28]}, 32'd0);
    endtask

    task automatic t_defer_hw;
        tick_pulse = 1'b1; nmi_req = 1'b1; irq_pend = 8'hFF; irq_en = 8'hFF;
        @(negedge clk);
        tick_pulse = 1'b0; nmi_req = 1'b0;
        @(negedge clk);
        check("R4 hw cannot set", {31'b0, rd_data[28]}, 32'd0);
        irq_pend = '0; irq_en = '0;
        ack(9'd2);
        wr(32'h0200_0000);
        check("R4 cleanup", rd_data, 32'h0000_0002);
    endtask

    task automatic t_tick;
        wr(32'h0400_0000);
        check("R5 set", {31'b0, rd_data[26]}, 32'd1);
        check("R5 clear bit reads 0", {31'b0, rd_data[25]}, 32'd0);
        wr(32'h0200_0000);
        check("R5 clear", {31'b0, rd_data[26]}, 32'd0);
        tick_pulse = 1'b1; @(negedge clk); tick_pulse = 1'b0;
        check("R5 tick sets", {31'b0, rd_data[26]}, 32'd1);
        wr(32'h0600_0000);
        check("R5 clear wins", {31'b0, rd_data[26]}, 32'd0);
    endtask

    task automatic t_prio;
        check("R6 none pending", {23'b0, rd_data[20:12]}, 32'd0);
        defer_prio = 3'd3; tick_prio = 3'd3;
        wr(32'h1400_0000);
        check("R6 tie lower number", {23'b0, rd_data[20:12]}, 32'd14);
        tick_prio = 3'd1; #1;
        check("R6 lower value wins", {23'b0, rd_data[20:12]}, 32'd15);
        irq_prio = '0; irq_prio[3*PRIO_W +: PRIO_W] = 3'd0;
        irq_pend = 8'h08; irq_en = 8'h08; #1;
        check("R6 external wins", {23'b0, rd_data[20:12]}, 32'd19);
        wr(32'h8000_0000);
        check("R6 NMI wins", {23'b0, rd_data[20:12]}, 32'd2);
        ack(9'd2);
    endtask

    task automatic t_gate;
        irq_pend = 8'h20; irq_en = 8'h20; irq_mask = 8'h20;
        irq_prio = '0; tick_prio = 3'd5; defer_prio = 3'd6; #1;
        check("R7 masked skipped", {23'b0, rd_data[20:12]}, 32'd15);
        irq_mask = '0; irq_en = '0; #1;
        check("R7 disabled skipped", {23'b0, rd_data[20:12]}, 32'd15);
        check("R8 raw flag", {31'b0, rd_data[22]}, 32'd1);
        irq_en = 8'h20; #1;
        check("R7 eligible chosen", {23'b0, rd_data[20:12]}, 32'd21);
        irq_pend = '0; irq_en = '0; #1;
        check("R8 flag clear", {31'b0, rd_data[22]}, 32'd0);
    endtask

    task automatic t_ack;
        ack(9'd15);
        check("R9 active 15", {23'b0, rd_data[8:0]}, 32'd15);
        check("R9 ack clears timer", {31'b0, rd_data[26]}, 32'd0);
        ack(9'd14);
        check("R9 ack clears defer", {31'b0, rd_data[28]}, 32'd0);
        halt_preempt = 1'b1; #1;
        check("R9 preempt mirror", {31'b0, rd_data[23]}, 32'd1);
        halt_preempt = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; nmi_req = 1'b0; tick_pulse = 1'b0;
        irq_pend = '0; irq_en = '0; irq_mask = '0; defer_prio = '0; tick_prio = '0;
        irq_prio = '0; ack_valid = 1'b0; ack_num = '0; halt_preempt = 1'b0;
        @(negedge clk);
        t_reset();
        t_nmi();
        t_defer();
        t_defer_hw();
        t_tick();
        t_prio();
        t_gate();
        t_ack();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule